// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory interface. It runs on a fast system clock and oversamples the clock and data lines of the bus. From those samples it finds the bus framing events and shifts bytes in and out. It decides whether a transfer is addressed to it and answers with acknowledges. It also runs the write and read sequences against an external storage array. The storage array is not part of the block. The block tells it which word to write or fetch through a word pointer, a write strobe and a read request.

The bus data line is open-drain. The block never drives it high. It only asserts an enable that pulls the line low. The integrator combines that enable with a pull-up, and the resolved line level comes back in on `sda_i`. Three strap inputs give the low bits of the device select code, so several devices can share one bus. While the storage is busy programming, `busy_i` is held high, and the block then refuses to be selected.

Top module: `tw_mem_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins device-select reception from any state. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released. Bus activity before the first START is not acted on.
- R2: In the device-select byte, bits 7:4 must equal 1010 and bits 3:1 must equal `strap_i[2:0]`; bit 0 is the direction, with 1 meaning read. On a match the block pulls SDA low for the whole ninth clock. On a mismatch it never drives SDA and ignores the bus until the next START.
- R3: If `busy_i` is high when a matching device-select byte completes, no acknowledge is given and the block ignores the bus until the next START.
- R4: A write selection is followed by two word-address bytes, and the block acknowledges each one. Bits 4:0 of the first byte become `waddr_o[12:8]` and its bits 7:5 are ignored. The second byte becomes `waddr_o[7:0]`.
- R5: Each data byte after the address bytes is acknowledged and placed on `wdata_o`. At the same time `wdata_vld_o` is high for exactly one clock, and during that clock `waddr_o` holds the target address.
- R6: After each written byte, `waddr_o[4:0]` advances by one and wraps inside its 32-byte page. `waddr_o[12:5]` stays unchanged.
- R7: On a read, `rd_req_o` pulses for one clock while `waddr_o` holds the address. `rdata_i` must hold that byte from the next clock until the second rising edge after the pulse. The byte is sent MSB first. The pointer then advances by one across the whole 13-bit space, so 0x1FFF wraps to 0x0000.
- R8: If the master pulls SDA low on the ninth clock of a read byte, the next byte is requested and sent. If the master leaves SDA high there (a NACK), SDA stays released, no further request is made, and the block waits for STOP or START.
- R9: A repeated START in the middle of a transaction restarts device-select reception and leaves the word address unchanged. A read selected after it returns data from the stored address.
- R10: `sda_oe_o` changes only while SCL is low. The only exception is the release forced by a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level, asynchronous |
| sda_i | input | 1 | Resolved bus data line level, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device select strap bits |
| busy_i | input | 1 | Storage programming in progress |
| waddr_o | output | 13 | Current word pointer |
| wdata_o | output | 8 | Received data byte |
| wdata_vld_o | output | 1 | One-clock strobe for `wdata_o` at `waddr_o` |
| rd_req_o | output | 1 | One-clock read request for the byte at `waddr_o` |
| rdata_i | input | 8 | Byte returned for the last read request |

## Verification
Some properties are checked on every clock. SDA is never driven while the block is idle. The enable only moves while SCL is low. No acknowledge is given when busy is high at selection. The read and write strobes are single, mutually exclusive pulses. The pointer keeps its page bits across a write increment. Other behaviour can only be shown by the directed bus scenarios. These cover the decoding of the select byte and the strap pins, the exact target addresses and the page wrap, and the byte values returned in sequential and wrapping reads. They also cover the end of a read on a master NACK and the pointer kept across a repeated START.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int          BYTE_BITS  = 8;
    localparam logic [3:0]  DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } tw_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } tw_evt_t;

    typedef struct packed {
        logic       ld_hi;
        logic       ld_lo;
        logic       inc_page;
        logic       inc_full;
        logic [7:0] val;
    } tw_ptr_cmd_t;

    function automatic logic dev_hit(input logic [7:0] sel, input logic [2:0] strap);
        return (sel[7:4] == DEV_PREFIX) && (sel[3:1] == strap);
    endfunction

endpackage

// File: rtl/tw_line_cond.sv
module tw_line_cond
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output tw_evt_t evt
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][1:0] stage;
    logic [1:0]                  prev;
    logic                        scl_now, sda_now, scl_was, sda_was;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '1;
            prev  <= 2'b11;
        end else begin
            stage[0] <= {scl_i, sda_i};
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
            prev <= stage[LAST];
        end
    end

    assign scl_now = stage[LAST][1];
    assign sda_now = stage[LAST][0];
    assign scl_was = prev[1];
    assign sda_was = prev[0];

    always_comb begin
        evt.scl   = scl_now;
        evt.sda   = sda_now;
        evt.start = scl_now & scl_was & sda_was & ~sda_now;
        evt.stop  = scl_now & scl_was & ~sda_was & sda_now;
        evt.rise  = scl_now & ~scl_was;
        evt.fall  = ~scl_now & scl_was;
    end

endmodule

// File: rtl/tw_bit_ctr.sv
module tw_bit_ctr
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda,
    output logic [3:0] bit_cnt,
    output logic       in_ack,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       ack_rise,
    output logic       ack_end
);

    localparam logic [3:0] FULL = 4'(BYTE_BITS);

    always_comb begin
        byte_done = scl_fall && !in_ack && (bit_cnt == FULL);
        ack_rise  = scl_rise && in_ack;
        ack_end   = scl_fall && in_ack;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            rx_byte <= '0;
        end else begin
            if (scl_rise && !in_ack && (bit_cnt < FULL)) begin
                rx_byte <= {rx_byte[6:0], sda};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if (byte_done) begin
                in_ack <= 1'b1;
            end
            if (ack_end) begin
                in_ack  <= 1'b0;
                bit_cnt <= '0;
            end
        end
    end

    AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (rst)
        in_ack |-> (bit_cnt == FULL)) else $error("ack phase without a full byte"); // R2

endmodule

// File: rtl/tw_addr_ptr.sv
module tw_addr_ptr
    import tw_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  tw_ptr_cmd_t       cmd,
    output logic [ADDR_W-1:0] ptr
);

    localparam int HI_W = ADDR_W - BYTE_BITS;

    logic [ADDR_W-1:0] ptr_page_inc;

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            assign ptr_page_inc = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

            AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
                cmd.inc_page |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])))
                else $error("page bits moved on a write increment"); // R6
        end else begin : g_flat
            assign ptr_page_inc = ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (cmd.ld_hi) begin
            ptr[ADDR_W-1:BYTE_BITS] <= cmd.val[HI_W-1:0];
        end else if (cmd.ld_lo) begin
            ptr[BYTE_BITS-1:0] <= cmd.val;
        end else if (cmd.inc_page) begin
            ptr <= ptr_page_inc;
        end else if (cmd.inc_full) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.ld_hi, cmd.ld_lo, cmd.inc_page, cmd.inc_full}))
        else $error("conflicting pointer commands"); // R5

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [7:0]        wdata_o,
    output logic              wdata_vld_o,
    output logic              rd_req_o,
    input  logic [7:0]        rdata_i
);

    tw_evt_t     evt;
    tw_state_e   state;
    tw_ptr_cmd_t ptr_cmd;

    logic [3:0] bit_cnt;
    logic       in_ack, byte_done, ack_rise, ack_end;
    logic [7:0] rx_byte;
    logic       bit_clear;

    logic       oe_q, own_ack, nack_end;
    logic [7:0] tx_byte;
    logic       rd_req_q, rd_pend, wvld_q, ld_hi_q, ld_lo_q;
    logic [7:0] wdata_q, ld_val_q;

    tw_line_cond #(.SYNC_STAGES(SYNC_STAGES)) line_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    assign bit_clear = evt.start || evt.stop || (state == ST_IDLE);

    tw_bit_ctr bits_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (bit_clear),
        .scl_rise  (evt.rise),
        .scl_fall  (evt.fall),
        .sda       (evt.sda),
        .bit_cnt   (bit_cnt),
        .in_ack    (in_ack),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .ack_rise  (ack_rise),
        .ack_end   (ack_end)
    );

    always_comb begin
        ptr_cmd.ld_hi    = ld_hi_q;
        ptr_cmd.ld_lo    = ld_lo_q;
        ptr_cmd.inc_page = wvld_q;
        ptr_cmd.inc_full = rd_req_q;
        ptr_cmd.val      = ld_val_q;
    end

    tw_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) ptr_i (
        .clk (clk),
        .rst (rst),
        .cmd (ptr_cmd),
        .ptr (waddr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            oe_q     <= 1'b0;
            own_ack  <= 1'b0;
            nack_end <= 1'b0;
            tx_byte  <= '0;
            rd_req_q <= 1'b0;
            rd_pend  <= 1'b0;
            wvld_q   <= 1'b0;
            wdata_q  <= '0;
            ld_hi_q  <= 1'b0;
            ld_lo_q  <= 1'b0;
            ld_val_q <= '0;
        end else begin
            rd_req_q <= 1'b0;
            wvld_q   <= 1'b0;
            ld_hi_q  <= 1'b0;
            ld_lo_q  <= 1'b0;
            rd_pend  <= rd_req_q;
            if (rd_pend) begin
                tx_byte <= rdata_i;
            end

            if (evt.start) begin
                state    <= ST_DEV;
                oe_q     <= 1'b0;
                own_ack  <= 1'b0;
                nack_end <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                oe_q     <= 1'b0;
                own_ack  <= 1'b0;
                nack_end <= 1'b0;
            end else if (byte_done) begin
                unique case (state)
                    ST_DEV: begin
                        if (dev_hit(rx_byte, strap_i) && !busy_i) begin
                            oe_q    <= 1'b1;
                            own_ack <= 1'b1;
                            if (rx_byte[0]) begin
                                state    <= ST_RDAT;
                                rd_req_q <= 1'b1;
                            end else begin
                                state <= ST_AHI;
                            end
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_AHI: begin
                        ld_hi_q  <= 1'b1;
                        ld_val_q <= rx_byte;
                        oe_q     <= 1'b1;
                        own_ack  <= 1'b1;
                        state    <= ST_ALO;
                    end
                    ST_ALO: begin
                        ld_lo_q  <= 1'b1;
                        ld_val_q <= rx_byte;
                        oe_q     <= 1'b1;
                        own_ack  <= 1'b1;
                        state    <= ST_WDAT;
                    end
                    ST_WDAT: begin
                        wvld_q  <= 1'b1;
                        wdata_q <= rx_byte;
                        oe_q    <= 1'b1;
                        own_ack <= 1'b1;
                    end
                    ST_RDAT: begin
                        oe_q    <= 1'b0;
                        own_ack <= 1'b0;
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end else if (ack_rise) begin
                if ((state == ST_RDAT) && !own_ack) begin
                    if (!evt.sda) begin
                        rd_req_q <= 1'b1;
                    end else begin
                        nack_end <= 1'b1;
                    end
                end
            end else if (ack_end) begin
                own_ack <= 1'b0;
                if (nack_end) begin
                    state    <= ST_IDLE;
                    oe_q     <= 1'b0;
                    nack_end <= 1'b0;
                end else if (state == ST_RDAT) begin
                    oe_q <= ~tx_byte[BYTE_BITS-1];
                end else begin
                    oe_q <= 1'b0;
                end
            end else if (evt.fall && (state == ST_RDAT) && !in_ack && (bit_cnt != 4'd0)) begin
                oe_q <= ~tx_byte[3'd7 - bit_cnt[2:0]];
            end
        end
    end

    assign sda_oe_o    = oe_q;
    assign wdata_o     = wdata_q;
    assign wdata_vld_o = wvld_q;
    assign rd_req_o    = rd_req_q;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !oe_q) else $error("SDA driven while idle"); // R2

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        (byte_done && (state == ST_DEV) && busy_i) |=> !oe_q) else $error("acknowledged while busy"); // R3

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> (!evt.scl || $past(evt.start || evt.stop)))
        else $error("SDA enable moved while SCL high"); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wvld_q, rd_req_q})) else $error("read and write strobes together"); // R5

    AST_WVLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        wvld_q |=> !wvld_q) else $error("write strobe longer than one clock"); // R5

    AST_RDREQ_IN_READ: assert property (@(posedge clk) disable iff (rst)
        rd_req_q |-> (state == ST_RDAT)) else $error("read request outside a read"); // R7

endmodule

// File: tb/tw_mem_slave_tb_top.sv
module tw_mem_slave_tb_top;

    localparam int AW = 13;
    localparam int Q  = 6;
    localparam int H  = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          busy  = 1'b0;
    logic [2:0]    strap = 3'b101;
    logic          sda_oe;
    logic          sda_line;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;
    logic [7:0]    rdata = 8'h00;
    logic          wvld, rdreq;

    assign sda_line = sda_m & ~sda_oe;

    tw_mem_slave dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (strap),
        .busy_i      (busy),
        .waddr_o     (waddr),
        .wdata_o     (wdata),
        .wdata_vld_o (wvld),
        .rd_req_o    (rdreq),
        .rdata_i     (rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_w = 0;
    int n_r = 0;
    logic [7:0]    cap_d [32];
    logic [AW-1:0] cap_a [32];

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[12:8], 3'b011};
    endfunction

    always @(negedge clk) begin
        if (wvld) begin
            cap_d[n_w % 32] <= wdata;
            cap_a[n_w % 32] <= waddr;
            n_w <= n_w + 1;
        end
        if (rdreq) begin
            rdata <= pat(waddr);
            n_r <= n_r + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b1; cyc(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; cyc(Q);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic get_bit(output logic b);
        logic s1;
        sda_m = 1'b1; cyc(Q);
        scl_m = 1'b1; cyc(3);
        s1 = sda_line;
        cyc(H - 3);
        b = sda_line;
        chk("R10 line stable while SCL high", 32'(b), 32'(s1));
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            v[i] = x;
        end
        put_bit(~mack);
    endtask

    task automatic t_reset;
        chk("R1 reset sda_oe", 32'(sda_oe), 32'd0);
        chk("R1 reset wdata_vld", 32'(wvld), 32'd0);
        chk("R1 reset rd_req", 32'(rdreq), 32'd0);
    endtask

    task automatic t_no_start;
        logic ack;
        int w0, r0;
        w0 = n_w; r0 = n_r;
        scl_m = 1'b0; cyc(Q);
        wr_byte(8'hAB, ack);
        chk("R1 no ack without START", 32'(ack), 32'd0);
        wr_byte(8'h12, ack);
        chk("R1 no strobes without START", 32'(n_w - w0 + n_r - r0), 32'd0);
        bus_stop;
    endtask

    task automatic t_write_page;
        logic ack;
        int w0;
        w0 = n_w;
        bus_start;
        wr_byte(8'hAA, ack); chk("R2 select write ack", 32'(ack), 32'd1);
        wr_byte(8'hE3, ack); chk("R4 high address ack", 32'(ack), 32'd1);
        wr_byte(8'h1E, ack); chk("R4 low address ack", 32'(ack), 32'd1);
        wr_byte(8'h5A, ack); chk("R5 data 0 ack", 32'(ack), 32'd1);
        wr_byte(8'hC3, ack); chk("R5 data 1 ack", 32'(ack), 32'd1);
        wr_byte(8'h77, ack); chk("R5 data 2 ack", 32'(ack), 32'd1);
        bus_stop;
        chk("R5 one strobe per byte", 32'(n_w - w0), 32'd3);
        chk("R4 first target address", 32'(cap_a[w0 % 32]), 32'h031E);
        chk("R5 first data", 32'(cap_d[w0 % 32]), 32'h5A);
        chk("R6 second target address", 32'(cap_a[(w0 + 1) % 32]), 32'h031F);
        chk("R5 second data", 32'(cap_d[(w0 + 1) % 32]), 32'hC3);
        chk("R6 page wrap address", 32'(cap_a[(w0 + 2) % 32]), 32'h0300);
        chk("R5 third data", 32'(cap_d[(w0 + 2) % 32]), 32'h77);
        chk("R1 released after STOP", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_mismatch;
        logic ack;
        int w0;
        w0 = n_w;
        bus_start;
        wr_byte(8'hA0, ack); chk("R2 strap mismatch no ack", 32'(ack), 32'd0);
        wr_byte(8'h12, ack); chk("R2 ignored after mismatch", 32'(ack), 32'd0);
        wr_byte(8'h34, ack);
        wr_byte(8'h56, ack);
        chk("R2 no write after mismatch", 32'(n_w - w0), 32'd0);
        bus_stop;
        bus_start;
        wr_byte(8'hBA, ack); chk("R2 prefix mismatch no ack", 32'(ack), 32'd0);
        bus_stop;
    endtask

    task automatic t_busy;
        logic ack;
        busy = 1'b1;
        bus_start;
        wr_byte(8'hAA, ack); chk("R3 no ack while busy", 32'(ack), 32'd0);
        wr_byte(8'h00, ack); chk("R3 ignored after busy refusal", 32'(ack), 32'd0);
        bus_stop;
        busy = 1'b0;
    endtask

    task automatic t_random_read;
        logic ack;
        logic [7:0] v;
        int r0;
        bus_start;
        wr_byte(8'hAA, ack);
        wr_byte(8'h12, ack);
        wr_byte(8'h34, ack);
        bus_start;
        r0 = n_r;
        wr_byte(8'hAB, ack); chk("R2 select read ack", 32'(ack), 32'd1);
        rd_byte(v, 1'b1); chk("R9 read at stored address", 32'(v), 32'(pat(13'h1234)));
        rd_byte(v, 1'b1); chk("R8 sequential byte 1", 32'(v), 32'(pat(13'h1235)));
        rd_byte(v, 1'b0); chk("R8 sequential byte 2", 32'(v), 32'(pat(13'h1236)));
        chk("R8 released after NACK", 32'(sda_oe), 32'd0);
        chk("R8 no request after NACK", 32'(n_r - r0), 32'd3);
        bus_stop;
    endtask

    task automatic t_current_read;
        logic ack;
        logic [7:0] v;
        bus_start;
        wr_byte(8'hAB, ack); chk("R2 select read ack", 32'(ack), 32'd1);
        rd_byte(v, 1'b0); chk("R7 read continues at pointer", 32'(v), 32'(pat(13'h1237)));
        bus_stop;
    endtask

    task automatic t_read_wrap;
        logic ack;
        logic [7:0] v;
        bus_start;
        wr_byte(8'hAA, ack);
        wr_byte(8'hFF, ack); chk("R4 high byte ack", 32'(ack), 32'd1);
        wr_byte(8'hFF, ack);
        bus_start;
        wr_byte(8'hAB, ack);
        rd_byte(v, 1'b1); chk("R4 upper bits ignored", 32'(v), 32'(pat(13'h1FFF)));
        rd_byte(v, 1'b0); chk("R7 pointer wraps to zero", 32'(v), 32'(pat(13'h0000)));
        bus_stop;
    endtask

    task automatic t_restart_mid_write;
        logic ack;
        logic [7:0] v;
        int w0;
        w0 = n_w;
        bus_start;
        wr_byte(8'hAA, ack);
        wr_byte(8'h05, ack);
        wr_byte(8'h00, ack);
        wr_byte(8'h99, ack);
        chk("R5 written target", 32'(cap_a[w0 % 32]), 32'h0500);
        bus_start;
        wr_byte(8'hAB, ack); chk("R9 select after repeated START", 32'(ack), 32'd1);
        rd_byte(v, 1'b0); chk("R9 pointer kept across restart", 32'(v), 32'(pat(13'h0501)));
        bus_stop;
        chk("R1 idle after STOP", 32'(sda_oe), 32'd0);
    endtask

    initial begin
        cyc(150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cyc(5);
        rst = 1'b0;
        cyc(5);
        t_reset;
        t_no_start;
        t_write_page;
        t_mismatch;
        t_busy;
        t_random_read;
        t_current_read;
        t_read_wrap;
        t_restart_mid_write;
        cyc(10);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule